// File: doc/BRIEF.md
# ARINC 429 Serial Word Transmitter

This block sends 32-bit avionics words on a bipolar return-to-zero line pair. A host loads each word as two 16-bit writes into a 32-word queue. While the start input is held high, the block takes words from the head of the queue one at a time. For each word it shifts out 32 bit cells. Each cell has a data phase, on one of two line outputs, followed by a null phase. After the last bit the lines stay quiet for an inter-word gap.

The 32nd bit can carry odd parity or even parity over the first 31 bits, or it can carry the host's own bit unchanged. A speed input chooses between a fast and a slow timing set, and all phases are counted in master clocks. A flag reports when the queue is empty and no word is on the line. A synchronous master reset stops the line at once and empties the queue.

Top module: `a429_tx_top`

## Requirements
- R1: A write with `wr_upper`=0 stores the lower half (word bits 15:0). A later write with `wr_upper`=1 commits {upper, lower} to the queue. A lower-half write alone commits nothing and starts no transmission.
- R2: The queue holds 32 words. `fifo_full` is high when it holds 32. A word committed while the queue is full is discarded.
- R3: No word is sent while `tx_enable` is low. When `tx_enable` is high and the queue is not empty, the first data phase appears on the lines two clock cycles after the cycle in which enable is first sampled high.
- R4: In a data phase exactly one line is high: `line_pos` for a one, `line_neg` for a zero. In null phases and gaps both lines are low.
- R5: With `speed_hi`=1, each bit is 5 clocks of data followed by 5 clocks of null. When another word is queued and enable is high, the next word's first data phase follows exactly 40 quiet clocks after the last bit's null phase.
- R6: With `speed_hi`=0, each bit is 40 clocks of data followed by 40 clocks of null, and the gap between queued words is 320 quiet clocks.
- R7: Transmission order: word bits 7 down to 0 go first (label, most significant first), then bits 8 up to 31.
- R8: With `parity_en`=1, bit 31 is replaced. With `parity_even`=0 it makes the count of ones in all 32 bits odd; with `parity_even`=1 it makes that count even.
- R9: With `parity_en`=0, all 32 written bits are sent unchanged, bit 31 included.
- R10: `tx_ready` is high exactly when the queue is empty and no word is being sent or in its trailing gap. While `tx_ready` is high both lines are low.
- R11: Master reset (`rst` high at a clock edge) drives both lines low by the next edge, empties the queue, discards a pending lower half, and sets `tx_ready` high and `fifo_full` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high master reset |
| wr_en | input | 1 | Host write strobe |
| wr_upper | input | 1 | 0 selects the lower half, 1 selects the upper half (commits the word) |
| wr_data | input | 16 | Half-word write data |
| tx_enable | input | 1 | Allows words to be taken from the queue and sent |
| speed_hi | input | 1 | 1 selects fast timing, 0 selects slow timing (sampled per word) |
| parity_en | input | 1 | 1 replaces bit 31 with a parity bit |
| parity_even | input | 1 | Parity sense when parity is enabled (0 odd, 1 even) |
| line_pos | output | 1 | Positive line, high during the data phase of a one |
| line_neg | output | 1 | Negative line, high during the data phase of a zero |
| tx_ready | output | 1 | Queue empty and line idle |
| fifo_full | output | 1 | Queue holds 32 words |

## Verification
A bad phase or bit counter shows at the ports within one bit cell: a data or null phase of the wrong length, or a word with more or fewer than 32 cells, followed by a gap of the wrong length. Errors in the reordering or parity logic show as a wrong received word on the very first transmission. A queue pointer or count error shows as a lost, repeated or extra word when a full queue drains, or as a wrong `fifo_full` or `tx_ready` level. A reset that misses some state shows as line activity or a stale word after reset while enable stays high.

// File: rtl/a429_pkg.sv
package a429_pkg;

  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DATA,
    ST_NULL,
    ST_GAP
  } tx_state_e;

  // Apply parity to bit 31, then place the bits in line order, so that
  // position 0 is the first bit sent.
  function automatic logic [WORD_W-1:0] frame_word(
    input logic [WORD_W-1:0] w,
    input logic              par_en,
    input logic              par_even
  );
    logic [WORD_W-1:0] p;
    logic [WORD_W-1:0] o;
    p = w;
    if (par_en) p[WORD_W-1] = par_even ? (^w[WORD_W-2:0]) : ~(^w[WORD_W-2:0]);
    for (int k = 0; k < 8; k++) o[k] = p[7-k];
    for (int k = 8; k < WORD_W; k++) o[k] = p[k];
    return o;
  endfunction

endpackage

// File: rtl/a429_word_pack.sv
module a429_word_pack
  import a429_pkg::*;
#(
  parameter int HW = HALF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_upper,
  input  logic [HW-1:0] wr_data,
  output logic          push,
  output logic [2*HW-1:0] push_word
);

  logic [HW-1:0] lo_q;
  logic          lo_valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q       <= '0;
      lo_valid_q <= 1'b0;
      push       <= 1'b0;
      push_word  <= '0;
    end else begin
      push <= 1'b0;
      if (wr_en && !wr_upper) begin
        lo_q       <= wr_data;
        lo_valid_q <= 1'b1;
      end else if (wr_en && wr_upper && lo_valid_q) begin
        push       <= 1'b1;
        push_word  <= {wr_data, lo_q};
        lo_valid_q <= 1'b0;
      end
    end
  end

  // R1
  commit_src_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> $past(wr_en && wr_upper));

endmodule

// File: rtl/a429_fifo.sv
module a429_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          empty,
  output logic          full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign empty   = (count_q == '0);
  assign full    = (count_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // Storage without reset so that a RAM block can hold it.
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= push_data;
    if (do_pop)  pop_data    <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> $stable(count_q));

  // R2
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));

endmodule

// File: rtl/a429_serializer.sv
module a429_serializer
  import a429_pkg::*;
#(
  parameter int HS_HALF = 5,
  parameter int LS_HALF = 40,
  parameter int HS_GAP  = 40,
  parameter int LS_GAP  = 320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              speed_hi,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              fifo_empty,
  output logic              pop,
  input  logic [WORD_W-1:0] pop_data,
  output logic              line_pos,
  output logic              line_neg,
  output logic              busy
);

  localparam int M1   = (HS_HALF > LS_HALF) ? HS_HALF : LS_HALF;
  localparam int M2   = (HS_GAP > LS_GAP) ? HS_GAP : LS_GAP;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int BW   = $clog2(WORD_W);

  tx_state_e         st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d, half_lim, gap_lim;
  logic [BW-1:0]     bit_q, bit_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              spd_q, spd_d, pre_q, pre_d;

  assign half_lim = spd_q ? CW'(HS_HALF - 1) : CW'(LS_HALF - 1);
  assign gap_lim  = spd_q ? CW'(HS_GAP - 1)  : CW'(LS_GAP - 1);
  assign busy     = (st_q != ST_IDLE);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    spd_d = spd_q;
    pre_d = pre_q;
    pop   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (enable && !fifo_empty) begin
          pop  = 1'b1;
          st_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        st_d  = ST_DATA;
        cnt_d = '0;
        bit_d = '0;
        sh_d  = frame_word(pop_data, par_en, par_even);
        spd_d = speed_hi;
      end
      ST_DATA: begin
        if (cnt_q == half_lim) begin
          st_d  = ST_NULL;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_NULL: begin
        if (cnt_q == half_lim) begin
          cnt_d = '0;
          if (bit_q == BW'(WORD_W - 1)) begin
            st_d  = ST_GAP;
            pre_d = 1'b0;
          end else begin
            st_d  = ST_DATA;
            bit_d = bit_q + 1'b1;
            sh_d  = sh_q >> 1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_q == gap_lim) begin
          pre_d = 1'b0;
          cnt_d = '0;
          if (pre_q) begin
            st_d  = ST_DATA;
            bit_d = '0;
            sh_d  = frame_word(pop_data, par_en, par_even);
            spd_d = speed_hi;
          end else begin
            st_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
          // Fetch the next word one cycle early so the gap stays exact.
          if (cnt_q == gap_lim - 1'b1 && enable && !fifo_empty) begin
            pop   = 1'b1;
            pre_d = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      spd_q    <= 1'b1;
      pre_q    <= 1'b0;
      line_pos <= 1'b0;
      line_neg <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      spd_q    <= spd_d;
      pre_q    <= pre_d;
      line_pos <= (st_d == ST_DATA) && sh_d[0];
      line_neg <= (st_d == ST_DATA) && !sh_d[0];
    end
  end

  // R4
  lines_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(line_pos && line_neg));

  // R4
  null_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_NULL || st_q == ST_GAP) |-> (!line_pos && !line_neg));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DATA && $past(st_q) == ST_DATA) |-> ($stable(line_pos) && $stable(line_neg)));

  // R3
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (!fifo_empty && enable));

endmodule

// File: rtl/a429_tx_top.sv
module a429_tx_top
  import a429_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int HS_HALF = 5,
  parameter int LS_HALF = 40,
  parameter int HS_GAP  = 40,
  parameter int LS_GAP  = 320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_upper,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              tx_enable,
  input  logic              speed_hi,
  input  logic              parity_en,
  input  logic              parity_even,
  output logic              line_pos,
  output logic              line_neg,
  output logic              tx_ready,
  output logic              fifo_full
);

  logic              push, pop, fifo_empty, busy;
  logic [WORD_W-1:0] push_word, pop_data;

  a429_word_pack #(.HW(HALF_W)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_upper  (wr_upper),
    .wr_data   (wr_data),
    .push      (push),
    .push_word (push_word)
  );

  a429_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (push_word),
    .pop       (pop),
    .pop_data  (pop_data),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  a429_serializer #(
    .HS_HALF (HS_HALF),
    .LS_HALF (LS_HALF),
    .HS_GAP  (HS_GAP),
    .LS_GAP  (LS_GAP)
  ) u_ser (
    .clk        (clk),
    .rst        (rst),
    .enable     (tx_enable),
    .speed_hi   (speed_hi),
    .par_en     (parity_en),
    .par_even   (parity_even),
    .fifo_empty (fifo_empty),
    .pop        (pop),
    .pop_data   (pop_data),
    .line_pos   (line_pos),
    .line_neg   (line_neg),
    .busy       (busy)
  );

  assign tx_ready = fifo_empty && !busy;

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!line_pos && !line_neg && !fifo_full && tx_ready));

  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (!line_pos && !line_neg));

endmodule

// File: tb/a429_tx_top_test.sv
`timescale 1ns/1ps
module a429_tx_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_upper = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tx_enable = 1'b0, speed_hi = 1'b1, parity_en = 1'b1, parity_even = 1'b0;
  logic        line_pos, line_neg, tx_ready, fifo_full;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  a429_tx_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_upper(wr_upper), .wr_data(wr_data),
    .tx_enable(tx_enable), .speed_hi(speed_hi), .parity_en(parity_en),
    .parity_even(parity_even), .line_pos(line_pos), .line_neg(line_neg),
    .tx_ready(tx_ready), .fifo_full(fifo_full)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_seq(input logic [31:0] w, input bit pe, input bit ev);
    logic [31:0] x, r;
    int ones;
    x = w;
    ones = 0;
    for (int i = 0; i < 31; i++) ones += int'(w[i]);
    if (pe) x[31] = ev ? (ones % 2 == 1) : (ones % 2 == 0);
    for (int k = 0; k < 8; k++) r[k] = x[7-k];
    for (int k = 8; k < 32; k++) r[k] = x[k];
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic write_half(input bit upper, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_upper = upper; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic write_word(input logic [31:0] w);
    write_half(1'b0, w[15:0]);
    write_half(1'b1, w[31:16]);
  endtask

  task automatic count_quiet(input int limit, output int n);
    n = 0;
    while (n < limit && !(line_pos || line_neg)) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Receives one word; ok clears on any phase-length or level fault.
  task automatic get_word(input int half, output logic [31:0] seq, output bit ok);
    int q;
    logic lvl;
    ok = 1'b1;
    seq = '0;
    count_quiet(3000, q);
    if (!(line_pos || line_neg)) begin
      ok = 1'b0;
      return;
    end
    for (int b = 0; b < 32; b++) begin
      lvl = line_pos;
      for (int c = 0; c < half; c++) begin
        if (!(line_pos ^ line_neg) || line_pos != lvl) ok = 1'b0;
        @(negedge clk);
      end
      for (int c = 0; c < half; c++) begin
        if (line_pos || line_neg) ok = 1'b0;
        @(negedge clk);
      end
      seq[b] = lvl;
    end
  endtask

  task automatic t_reset_state();
    chk("R11 line_pos after reset", 32'(line_pos), 0);
    chk("R11 line_neg after reset", 32'(line_neg), 0);
    chk("R10 ready after reset", 32'(tx_ready), 1);
    chk("R2 full after reset", 32'(fifo_full), 0);
  endtask

  task automatic t_single(input logic [31:0] w, input bit pe, input bit ev, input bit hs,
                          input string tag);
    logic [31:0] seq;
    bit ok;
    int n, half, gap;
    half = hs ? 5 : 40;
    gap  = hs ? 40 : 320;
    parity_en = pe; parity_even = ev; speed_hi = hs;
    write_word(w);
    @(negedge clk);
    chk({tag, " R10 ready low with word queued"}, 32'(tx_ready), 0);
    tx_enable = 1'b1;
    n = 0;
    @(negedge clk);
    while (!(line_pos || line_neg) && n < 10) begin n++; @(negedge clk); end
    chk({tag, " R3 start latency"}, n + 1, 2);
    get_word(half, seq, ok);
    chk({tag, hs ? " R5 bit timing" : " R6 bit timing"}, 32'(ok), 1);
    chk({tag, " word content"}, seq, ref_seq(w, pe, ev));
    count_quiet(gap + 10, n);
    chk({tag, " R4 quiet after last word"}, n, gap + 10);
    chk({tag, " R10 ready after drain"}, 32'(tx_ready), 1);
    tx_enable = 1'b0;
  endtask

  task automatic t_pair(input bit hs);
    logic [31:0] s1, s2;
    bit ok1, ok2;
    int n, half, gap;
    half = hs ? 5 : 40;
    gap  = hs ? 40 : 320;
    speed_hi = hs; parity_en = 1'b1; parity_even = 1'b0;
    write_word(32'h1234_56A1);
    write_word(32'h0F0F_3C5E);
    count_quiet(50, n);
    chk("R3 no output while enable low", n, 50);
    tx_enable = 1'b1;
    get_word(half, s1, ok1);
    count_quiet(gap + 20, n);
    chk(hs ? "R5 inter-word gap" : "R6 inter-word gap", n, gap);
    get_word(half, s2, ok2);
    chk(hs ? "R5 pair timing" : "R6 pair timing", 32'(ok1 && ok2), 1);
    chk("R7 first of pair", s1, ref_seq(32'h1234_56A1, 1, 0));
    chk("R7 second of pair", s2, ref_seq(32'h0F0F_3C5E, 1, 0));
    count_quiet(gap + 10, n);
    tx_enable = 1'b0;
  endtask

  task automatic t_half_only();
    int n;
    do_reset();
    write_half(1'b0, 16'hBEEF);
    repeat (3) @(negedge clk);
    chk("R1 ready after lower half only", 32'(tx_ready), 1);
    tx_enable = 1'b1;
    @(negedge clk);
    count_quiet(40, n);
    chk("R1 no transmission from lower half only", n, 40);
    tx_enable = 1'b0;
    do_reset();
  endtask

  task automatic t_full();
    logic [31:0] seq;
    bit ok;
    int n, bad;
    speed_hi = 1'b1; parity_en = 1'b0; parity_even = 1'b0;
    for (int i = 0; i < 32; i++) write_word(32'h0101_0101 * (i + 1) ^ 32'h8000_0000);
    @(negedge clk);
    chk("R2 full at 32 words", 32'(fifo_full), 1);
    write_word(32'hDEAD_BEEF);
    @(negedge clk);
    tx_enable = 1'b1;
    bad = 0;
    for (int i = 0; i < 32; i++) begin
      get_word(5, seq, ok);
      if (!ok || seq !== ref_seq(32'h0101_0101 * (i + 1) ^ 32'h8000_0000, 0, 0)) bad++;
      if (i == 0) chk("R2 full clears after first pop", 32'(fifo_full), 0);
    end
    chk("R9 all 32 queued words sent raw", bad, 0);
    count_quiet(400, n);
    chk("R2 word written while full dropped", n, 400);
    chk("R10 ready after full drain", 32'(tx_ready), 1);
    tx_enable = 1'b0;
  endtask

  task automatic t_master_reset();
    int n;
    speed_hi = 1'b1; parity_en = 1'b1;
    write_word(32'h1111_1111);
    write_word(32'h2222_2222);
    write_word(32'h3333_3333);
    tx_enable = 1'b1;
    count_quiet(20, n);
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 lines low after reset", 32'({line_pos, line_neg}), 0);
    chk("R11 ready after mid-word reset", 32'(tx_ready), 1);
    chk("R11 full low after reset", 32'(fifo_full), 0);
    count_quiet(200, n);
    chk("R11 queue emptied by reset", n, 200);
    tx_enable = 1'b0;
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    checks++;
    $display("FAIL R3 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_single(32'h6A5C_3E81, 1, 0, 1, "R8 odd");
    t_single(32'h6A5C_3E81, 1, 1, 1, "R8 even");
    t_single(32'h7FFF_00C3, 1, 0, 1, "R8 odd second");
    t_single(32'h8000_0001, 0, 0, 1, "R9 bypass top set");
    t_single(32'h7000_00FE, 0, 1, 1, "R9 bypass top clear");
    t_single(32'h0000_0080, 1, 1, 1, "R7 label msb");
    t_single(32'h00A5_5A01, 1, 0, 0, "R6 slow");
    t_pair(1'b1);
    t_pair(1'b0);
    t_half_only();
    t_full();
    t_master_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule